// File: doc/BRIEF.md
# Half-Bridge Fault Protection and Autorecovery Controller

This block is the digital protection core of a power stage with two half-bridges. It receives already-synchronised fault flags (overcurrent for each half-bridge, supply undervoltage and overtemperature error) and an overtemperature warning flag. It also receives an active-low hold input that mutes the stage, a two-bit protection mode selector and the PWM input of the stage. From these it drives one high-impedance command shared by both half-bridges and two active-low status outputs. Together the two status outputs tell a front-end controller why the stage stopped.

Three protection behaviours are supported. In the latching behaviour, a fault keeps the stage off until the hold input is pulsed low. In the self-recovering behaviour, the stage restarts on its own after a wait that is counted in PWM periods. The wait has two phases: the fault indication drops at half the count, and switching resumes at the full count. In the disabled behaviour, faults never stop the stage. The recovery length is a parameter, and the PWM input passes through a two-flop synchroniser before its rising edges are counted.

Top module: `bridge_guard`

## Requirements
- R1: `mode_sel` selects the behaviour: 2'b00 self-recovering, 2'b01 latching, 2'b10 protection disabled, 2'b11 (reserved) behaves exactly like latching.
- R2: With protection enabled and `hold_n` high, any of `ocp_a`, `ocp_b`, `uv_err`, `ot_err` high at a clock edge sets the trip latch. From that edge on, `hiz` is 1 and `sd_n` is 0.
- R3: In self-recovering mode, the trip latch clears (`sd_n` returns to 1) on the REC_CYCLES/2-th synchronised PWM rising edge after the fault. `hiz` stays 1 at that point.
- R4: In self-recovering mode, `hiz` returns to 0 on the REC_CYCLES-th synchronised PWM rising edge after the fault (default REC_CYCLES = 512).
- R5: A fault that arrives during either recovery phase sets the latch again and restarts the PWM edge count from zero.
- R6: In latching mode, a trip stays set whatever the PWM input does. The latch clears when `hold_n` falls, and switching resumes (`hiz` 0) once `hold_n` is high again.
- R7: While `hold_n` is 0, `hiz` is 1 and `sd_n` is 1, whatever the protection state.
- R8: The status pair {`otw_n`,`sd_n`} reads 2'b00 when tripped by an overtemperature error, 2'b10 when tripped by overcurrent or undervoltage only, 2'b01 when not tripped with `ot_warn` high, and 2'b11 when not tripped with no warning.
- R9: In disabled mode, fault flags never raise `hiz` or pull `sd_n` low, while `ot_warn` is still reported as `otw_n` = 0.
- R10: The PWM input passes through two flops. Only its rising edges advance the recovery count, so a PWM level held high for many clocks counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hold_n | input | 1 | Active-low mute/re-arm request (synchronous) |
| mode_sel | input | 2 | Protection behaviour select |
| pwm_in | input | 1 | PWM input of the stage (asynchronous) |
| ocp_a | input | 1 | Overcurrent flag, half-bridge A |
| ocp_b | input | 1 | Overcurrent flag, half-bridge B |
| uv_err | input | 1 | Gate supply undervoltage flag |
| ot_err | input | 1 | Overtemperature error flag |
| ot_warn | input | 1 | Overtemperature warning flag |
| hiz | output | 1 | Both half-bridges high-impedance when 1 |
| sd_n | output | 1 | Active-low protection status |
| otw_n | output | 1 | Active-low temperature status |

## Verification
A wrong trip latch appears on `sd_n` one clock after the fault edge. A wrong recovery counter shifts the `sd_n` release or the `hiz` release by one or more PWM periods, so the bench samples right after the 255th and the 256th edge and after the 511th and the 512th edge. A lost fault cause turns a status code of 00 into 10 at once. The restart case shows a counter that is not cleared: the stage would then release early, after fewer than 256 edges.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;

  typedef enum logic [1:0] {
    PM_AUTO  = 2'd0,
    PM_LATCH = 2'd1,
    PM_OFF   = 2'd2
  } prot_mode_e;

  // R1: reserved code maps onto latching behaviour
  function automatic prot_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'b00:   return PM_AUTO;
      2'b10:   return PM_OFF;
      default: return PM_LATCH;
    endcase
  endfunction

  // R8: returns {otw_n, sd_n}
  function automatic logic [1:0] status_pair(input logic hold_hi,
                                              input logic tripped,
                                              input logic ot_cause,
                                              input logic warn);
    if (hold_hi && tripped) return {~ot_cause, 1'b0};
    return {~warn, 1'b1};
  endfunction

  function automatic logic count_hits(input int unsigned cnt_now,
                                      input int unsigned target);
    return (cnt_now + 1) == target;
  endfunction

endpackage

// File: rtl/bg_pwm_sync.sv
module bg_pwm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  output logic rise
);
  logic [STAGES:0] chain;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pwm_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  // synchronised level is chain[STAGES-1]; chain[STAGES] is its previous value
  assign rise = chain[STAGES-1] & ~chain[STAGES];

  p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/bg_recov_timer.sv
module bg_recov_timer
  import bridge_guard_pkg::*;
#(
  parameter int unsigned REC_CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  input  logic tick,
  output logic half_hit,
  output logic full_hit
);
  localparam int unsigned HALF = REC_CYCLES / 2;
  localparam int unsigned CW   = $clog2(REC_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          step;

  assign step     = enable && tick && !restart;
  assign half_hit = step && count_hits(int'(cnt), HALF);
  assign full_hit = step && count_hits(int'(cnt), REC_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt <= '0;
    else if (restart)                     cnt <= '0;
    else if (step && int'(cnt) < REC_CYCLES) cnt <= cnt + 1'b1;
  end

  p_cnt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= REC_CYCLES);
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);

endmodule

// File: rtl/bg_trip_ctrl.sv
module bg_trip_ctrl
  import bridge_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  prot_mode_e mode,
  input  logic       hold_n,
  input  logic       err_now,
  input  logic       ot_now,
  input  logic       half_hit,
  input  logic       full_hit,
  output logic       err_evt,
  output logic       hold_fall,
  output logic       trip,
  output logic       busy,
  output logic       ot_cause
);
  logic hold_q;
  logic prot_on;
  logic is_auto;

  assign prot_on   = (mode != PM_OFF);
  assign is_auto   = (mode == PM_AUTO);
  assign hold_fall = hold_q && !hold_n;
  assign err_evt   = err_now && prot_on && hold_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip     <= 1'b0;
      busy     <= 1'b0;
      ot_cause <= 1'b0;
    end else if (!prot_on || hold_fall) begin
      trip     <= 1'b0;
      busy     <= 1'b0;
      ot_cause <= 1'b0;
    end else if (err_evt) begin
      trip     <= 1'b1;
      busy     <= is_auto;
      ot_cause <= (trip && ot_cause) || ot_now;
    end else if (is_auto) begin
      if (half_hit) begin
        trip     <= 1'b0;
        ot_cause <= 1'b0;
      end
      if (full_hit) busy <= 1'b0;
    end else begin
      busy <= 1'b0;
    end
  end

  p_err_trips_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> trip);
  p_fall_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fall |=> !trip && !busy);
  p_latch_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_LATCH && trip && !hold_fall) |=> trip);
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_OFF) |=> !trip && !busy);

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
  import bridge_guard_pkg::*;
#(
  parameter int unsigned REC_CYCLES  = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_n,
  input  logic [1:0] mode_sel,
  input  logic       pwm_in,
  input  logic       ocp_a,
  input  logic       ocp_b,
  input  logic       uv_err,
  input  logic       ot_err,
  input  logic       ot_warn,
  output logic       hiz,
  output logic       sd_n,
  output logic       otw_n
);
  prot_mode_e mode;
  logic       pwm_rise;
  logic       err_now;
  logic       err_evt;
  logic       hold_fall;
  logic       trip;
  logic       busy;
  logic       ot_cause;
  logic       half_hit;
  logic       full_hit;
  logic       tmr_restart;
  logic [1:0] status;

  assign mode        = decode_mode(mode_sel);
  assign err_now     = ocp_a | ocp_b | uv_err | ot_err;
  assign tmr_restart = err_evt | hold_fall | (mode != PM_AUTO);

  bg_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_in (pwm_in),
    .rise   (pwm_rise)
  );

  bg_recov_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (tmr_restart),
    .enable   (busy),
    .tick     (pwm_rise),
    .half_hit (half_hit),
    .full_hit (full_hit)
  );

  bg_trip_ctrl u_trip (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .hold_n    (hold_n),
    .err_now   (err_now),
    .ot_now    (ot_err),
    .half_hit  (half_hit),
    .full_hit  (full_hit),
    .err_evt   (err_evt),
    .hold_fall (hold_fall),
    .trip      (trip),
    .busy      (busy),
    .ot_cause  (ot_cause)
  );

  assign status = status_pair(hold_n, trip, ot_cause, ot_warn);
  assign otw_n  = status[1];
  assign sd_n   = status[0];
  assign hiz    = !hold_n || trip || busy;

  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |-> hiz && sd_n);
  p_sd_implies_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_n |-> hiz);
  p_mode_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> mode == PM_LATCH);

endmodule

// File: tb/sim_bridge_guard.sv
module sim_bridge_guard;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_n = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic pwm_in = 1'b0;
  logic ocp_a = 1'b0, ocp_b = 1'b0, uv_err = 1'b0, ot_err = 1'b0, ot_warn = 1'b0;
  logic hiz, sd_n, otw_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_guard u0 (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .mode_sel(mode_sel),
    .pwm_in(pwm_in), .ocp_a(ocp_a), .ocp_b(ocp_b), .uv_err(uv_err),
    .ot_err(ot_err), .ot_warn(ot_warn), .hiz(hiz), .sd_n(sd_n), .otw_n(otw_n)
  );

  // {mode[1:0], ocp_a, ocp_b, uv, ot, warn, exp_hiz, exp_sd_n, exp_otw_n}
  localparam logic [9:0] VEC [10] = '{
    10'b00_1000_0_101,  // R2 auto, overcurrent A
    10'b00_0010_0_101,  // R2 auto, undervoltage
    10'b01_0001_0_100,  // R8 latch, overtemp error
    10'b01_0100_1_101,  // R8 latch, overcurrent B with warning
    10'b10_1000_0_011,  // R9 disabled, fault ignored
    10'b10_0000_1_010,  // R9 disabled, warning reported
    10'b11_0010_0_101,  // R1 reserved trips like latch
    10'b00_0000_1_010,  // R8 warning only
    10'b00_0000_0_011,  // R8 normal
    10'b00_0001_1_100   // R8 auto, overtemp error with warning
  };

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {hiz,sd_n,otw_n} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hold_n = 1'b1;
    {ocp_a, ocp_b, uv_err, ot_err, ot_warn} = '0;
    pwm_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_fault(input logic [3:0] f);
    {ocp_a, ocp_b, uv_err, ot_err} = f;
    @(negedge clk);
    {ocp_a, ocp_b, uv_err, ot_err} = '0;
  endtask

  task automatic pwm_edges(input int n);
    for (int i = 0; i < n; i++) begin
      pwm_in = 1'b1; repeat (2) @(negedge clk);
      pwm_in = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state, hold low (R7)
    rst_n = 1'b0; hold_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset state hold low", {hiz, sd_n, otw_n}, 3'b111);

    // vector table: status and mode decoding
    for (int v = 0; v < 10; v++) begin
      do_reset();
      mode_sel = VEC[v][9:8];
      ot_warn  = VEC[v][3];
      @(negedge clk);
      pulse_fault(VEC[v][7:4]);
      chk($sformatf("R8 vector %0d", v), {hiz, sd_n, otw_n}, VEC[v][2:0]);
    end

    // R3 R4 R10: self recovery, first edge is a long high level
    do_reset(); mode_sel = 2'b00; @(negedge clk);
    pulse_fault(4'b1000);
    pwm_in = 1'b1; repeat (100) @(negedge clk);
    pwm_in = 1'b0; repeat (2) @(negedge clk);
    pwm_edges(254);
    chk("R10 long high counts once, 255 edges", {hiz, sd_n, otw_n}, 3'b101);
    pwm_edges(1);
    chk("R3 latch clears at edge 256", {hiz, sd_n, otw_n}, 3'b111);
    pwm_edges(255);
    chk("R4 still hiz at edge 511", {hiz, sd_n, otw_n}, 3'b111);
    pwm_edges(1);
    chk("R4 switching resumes at edge 512", {hiz, sd_n, otw_n}, 3'b011);

    // R5: restart during second phase
    pulse_fault(4'b0010);
    pwm_edges(300);
    chk("R5 second phase reached", {hiz, sd_n, otw_n}, 3'b111);
    pulse_fault(4'b0001);
    chk("R5 new overtemp error trips", {hiz, sd_n, otw_n}, 3'b100);
    pwm_edges(255);
    chk("R5 count restarted, 255 edges", {hiz, sd_n, otw_n}, 3'b100);
    pwm_edges(1);
    chk("R5 clears at 256 after restart", {hiz, sd_n, otw_n}, 3'b111);
    pwm_edges(256);
    chk("R5 resumes at 512 after restart", {hiz, sd_n, otw_n}, 3'b011);

    // R6: latching holds through pwm, re-armed by hold_n
    do_reset(); mode_sel = 2'b01; @(negedge clk);
    pulse_fault(4'b0100);
    pwm_edges(600);
    chk("R6 latch ignores pwm", {hiz, sd_n, otw_n}, 3'b101);
    hold_n = 1'b0; ot_warn = 1'b1; @(negedge clk);
    chk("R7 hold low forces sd_n high", {hiz, sd_n, otw_n}, 3'b110);
    ot_warn = 1'b0; @(negedge clk);
    hold_n = 1'b1; @(negedge clk);
    chk("R6 re-armed after hold toggle", {hiz, sd_n, otw_n}, 3'b011);

    // R1: reserved code also ignores pwm
    do_reset(); mode_sel = 2'b11; @(negedge clk);
    pulse_fault(4'b1000);
    pwm_edges(600);
    chk("R1 reserved stays latched", {hiz, sd_n, otw_n}, 3'b101);

    // R2: fault while hold low is not latched
    do_reset(); mode_sel = 2'b01; hold_n = 1'b0; @(negedge clk);
    pulse_fault(4'b0010);
    hold_n = 1'b1; @(negedge clk);
    chk("R2 fault with hold low not latched", {hiz, sd_n, otw_n}, 3'b011);

    // R9: persistent fault in disabled mode
    do_reset(); mode_sel = 2'b10; ocp_b = 1'b1; ot_err = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 persistent faults ignored", {hiz, sd_n, otw_n}, 3'b011);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule